// File: doc/BRIEF.md
# HDLC Frame Check Sequence Unit

This block is a bit-serial CRC engine shared by the transmit and receive sides of an HDLC link. A static width select picks the 16-bit CCITT polynomial (x^16 + x^12 + x^5 + 1) or the 32-bit polynomial (x^32 + x^26 + x^23 + x^22 + x^16 + x^12 + x^11 + x^10 + x^8 + x^7 + x^5 + x^4 + x^2 + x + 1). Bits are processed reflected, least significant first, and the register starts each frame at all ones.

On transmit, the framer clears the engine, presents each payload bit with a valid strobe, and then pulses a send strobe once per FCS bit. The serial output always shows the complement of the register's lowest bit. Each send pulse moves the register one place toward bit 0 and fills the top with a one. On receive, the deframer clears the engine and passes every frame bit through it, including the received FCS. A good frame leaves a fixed remainder, which the match flag reports.

Top module: `hdlc_fcs_unit`

## Requirements
- R1: After a reset cycle the register holds all ones, so `fcs_bit_o` is 0, `match_o` is 0, and reading out 32 send bits gives 0x00000000.
- R2: A `clr_i` pulse during a frame presets the register to all ones. A frame that follows gives the same FCS as one that starts after reset.
- R3: With `wide_i`=0, the ASCII message "123456789" (0x31..0x39, each byte sent LSB first) yields the FCS 0x906E. The FCS is read out bit 0 first.
- R4: With `wide_i`=1, the same message yields the FCS 0xCBF43926. A single 0x00 byte yields 0xD202EF8D.
- R5: `fcs_bit_o` is the complement of the register's bit 0, and the FCS is emitted lowest-order bit first. An empty frame therefore gives an FCS of all zeros.
- R6: A cycle in which none of `clr_i`, `bit_vld_i` and `send_i` is high leaves the register unchanged. Idle cycles between payload bits do not change the resulting FCS.
- R7: `match_o` is 1 when the active register equals the good-frame remainder: 0xF0B8 for 16-bit and 0xDEBB20E3 for 32-bit. A frame followed by its own FCS (LSB first) sets it.
- R8: A frame with a single flipped bit, in the payload or in the FCS, leaves `match_o` at 0.
- R9: Each `send_i` pulse shifts the active register one place toward bit 0 and enters a one at its top. After the full width has been sent, `fcs_bit_o` is 0.
- R10: Priority is `clr_i` over `bit_vld_i`, and `bit_vld_i` over `send_i`. When several are high in the same cycle, only the highest-priority operation takes effect.
- R11: In 16-bit mode, absorb and send operations leave the register's upper half unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset; presets the register to all ones |
| clr_i | input | 1 | Start-of-frame strobe; presets the register to all ones |
| bit_vld_i | input | 1 | Absorb `bit_i` into the CRC this cycle |
| bit_i | input | 1 | Serial data bit |
| wide_i | input | 1 | Width select: 0 = 16-bit, 1 = 32-bit (static within a frame) |
| send_i | input | 1 | Advance the FCS output by one bit |
| fcs_bit_o | output | 1 | Current FCS bit to transmit (complement of register bit 0) |
| match_o | output | 1 | Register equals the good-frame remainder for the selected width |

## Verification
A corrupted register bit shows up at the ports in one of two ways. The FCS bits read out afterwards differ from the known check values. Or, once the frame's own FCS has been fed back, `match_o` stays low. Because the CRC mixes every bit, a wrong feedback tap or a dropped bit changes the FCS result within the same frame. A wrong send fill or shift direction shows up within the width's worth of `send_i` pulses. A wrong priority or hold shows up in the first FCS read after the stimulus.

// File: rtl/hdlc_fcs_pkg.sv
// Package: constants shared by the HDLC FCS unit.
// Polynomials are stored reflected, for LSB-first processing.
// Residues are the register values left by a good frame.
package hdlc_fcs_pkg;
    localparam int unsigned NARROW_W = 16;
    localparam int unsigned WIDE_W   = 32;

    localparam logic [NARROW_W-1:0] POLY_NARROW = 16'h8408;
    localparam logic [WIDE_W-1:0]   POLY_WIDE   = 32'hEDB88320;

    localparam logic [NARROW_W-1:0] RES_NARROW  = 16'hF0B8;
    localparam logic [WIDE_W-1:0]   RES_WIDE    = 32'hDEBB20E3;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_CLEAR  = 2'd1,
        OP_ABSORB = 2'd2,
        OP_SEND   = 2'd3
    } fcs_op_e;
endpackage

// File: rtl/fcs_lane.sv
// fcs_lane: next-state logic for one CRC width.
// absorb_o: one reflected LFSR step that takes in data bit d_i.
// shift_o:  the state moved toward bit 0, with a one entered at the top.
// Assumes POLY is given in reflected form.
module fcs_lane #(
    parameter int unsigned W    = 16,
    parameter logic [W-1:0] POLY = '0
) (
    input  logic [W-1:0] state_i,
    input  logic         d_i,
    output logic [W-1:0] absorb_o,
    output logic [W-1:0] shift_o
);
    logic fb;

    // Reflected division step: feedback from bit 0 XOR the incoming data bit.
    always_comb begin
        fb       = state_i[0] ^ d_i;
        absorb_o = {1'b0, state_i[W-1:1]} ^ (fb ? POLY : '0);
    end

    // FCS readout step: shift toward bit 0 and fill the top with a one.
    always_comb begin
        shift_o = {1'b1, state_i[W-1:1]};
    end
endmodule

// File: rtl/fcs_residue_cmp.sv
// fcs_residue_cmp: flags when a CRC state equals the fixed good-frame remainder.
// Purely combinational; RES is the expected register value, not complemented.
module fcs_residue_cmp #(
    parameter int unsigned W   = 16,
    parameter logic [W-1:0] RES = '0
) (
    input  logic [W-1:0] state_i,
    output logic         eq_o
);
    // Compare the full state against the residue constant.
    always_comb begin
        eq_o = (state_i == RES);
    end
endmodule

// File: rtl/hdlc_fcs_unit.sv
// hdlc_fcs_unit: bit-serial HDLC FCS generator and checker, 16- or 32-bit.
// Holds one register of the wide width. In narrow mode only the low part is
// active and the upper part is left alone.
// Assumes wide_i is held static for the whole of a frame.
// Operation priority: clear, then absorb, then send.
module hdlc_fcs_unit
    import hdlc_fcs_pkg::*;
#(
    parameter int unsigned N_W    = NARROW_W,
    parameter int unsigned W_W    = WIDE_W,
    parameter logic [N_W-1:0] N_POLY = POLY_NARROW,
    parameter logic [W_W-1:0] W_POLY = POLY_WIDE,
    parameter logic [N_W-1:0] N_RES  = RES_NARROW,
    parameter logic [W_W-1:0] W_RES  = RES_WIDE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic wide_i,
    input  logic send_i,
    output logic fcs_bit_o,
    output logic match_o
);
    localparam int unsigned UPPER_W = W_W - N_W;
    localparam logic [W_W-1:0] PRESET = '1;

    logic [W_W-1:0] crc_q;
    logic [W_W-1:0] crc_d;
    logic [N_W-1:0] n_absorb, n_shift;
    logic [W_W-1:0] w_absorb, w_shift;
    logic           n_eq, w_eq;
    fcs_op_e        op;

    // Narrow and wide lanes both evaluate the current state every cycle.
    fcs_lane #(.W(N_W), .POLY(N_POLY)) u_lane_n (
        .state_i (crc_q[N_W-1:0]),
        .d_i     (bit_i),
        .absorb_o(n_absorb),
        .shift_o (n_shift)
    );

    fcs_lane #(.W(W_W), .POLY(W_POLY)) u_lane_w (
        .state_i (crc_q),
        .d_i     (bit_i),
        .absorb_o(w_absorb),
        .shift_o (w_shift)
    );

    fcs_residue_cmp #(.W(N_W), .RES(N_RES)) u_cmp_n (
        .state_i(crc_q[N_W-1:0]),
        .eq_o   (n_eq)
    );

    fcs_residue_cmp #(.W(W_W), .RES(W_RES)) u_cmp_w (
        .state_i(crc_q),
        .eq_o   (w_eq)
    );

    // Decode the strobes into a single operation, in priority order.
    always_comb begin
        if (clr_i)          op = OP_CLEAR;
        else if (bit_vld_i) op = OP_ABSORB;
        else if (send_i)    op = OP_SEND;
        else                op = OP_HOLD;
    end

    // Select the next register value for the chosen operation and width.
    always_comb begin
        unique case (op)
            OP_CLEAR:  crc_d = PRESET;
            OP_ABSORB: crc_d = wide_i ? w_absorb : {crc_q[W_W-1:N_W], n_absorb};
            OP_SEND:   crc_d = wide_i ? w_shift  : {crc_q[W_W-1:N_W], n_shift};
            default:   crc_d = crc_q;
        endcase
    end

    // CRC register with synchronous active-low reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= PRESET;
        else        crc_q <= crc_d;
    end

    // Outputs: complemented low bit, and residue match for the active width.
    always_comb begin
        fcs_bit_o = ~crc_q[0];
        match_o   = wide_i ? w_eq : n_eq;
    end

    // R1: a reset cycle leaves the register preset.
    p_reset_preset_r1: assert property (@(posedge clk)
        !rst_n |=> crc_q == PRESET);

    // R2: clear presets the register whatever else is strobed.
    p_clear_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> crc_q == PRESET);

    // R6: with no strobe, the register holds.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !bit_vld_i && !send_i) |=> $stable(crc_q));

    // R9: a wide send moves the register toward bit 0 and fills the top with a one.
    p_send_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !bit_vld_i && send_i && wide_i)
            |=> (crc_q[W_W-1] && crc_q[W_W-2:0] == $past(crc_q[W_W-1:1])));

    // R11: in narrow mode, absorb and send leave the upper part untouched.
    p_narrow_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && (bit_vld_i || send_i) && !wide_i)
            |=> crc_q[W_W-1:W_W-UPPER_W] == $past(crc_q[W_W-1:W_W-UPPER_W]));
endmodule

// File: tb/hdlc_fcs_unit_tb.sv
`timescale 1ns/1ps
module hdlc_fcs_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, wide_i = 1'b0, send_i = 1'b0;
    logic fcs_bit_o, match_o;
    int   n_checks = 0;
    int   n_errors = 0;

    always #2 clk = ~clk;

    hdlc_fcs_unit u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .bit_vld_i(bit_vld_i),
        .bit_i(bit_i), .wide_i(wide_i), .send_i(send_i),
        .fcs_bit_o(fcs_bit_o), .match_o(match_o)
    );

    // Vector table: width, message selector, expected FCS.
    // Messages: 0 = empty, 1 = "123456789", 2 = one 0x00 byte.
    localparam int NV = 5;
    localparam logic        V_WIDE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam int          V_SEL  [NV] = '{0, 0, 1, 1, 2};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0000, 32'h0, 32'h906E,
                                            32'hCBF43926, 32'hD202EF8D};

    function automatic int msg_len(input int sel);
        return (sel == 0) ? 0 : (sel == 1) ? 9 : 1;
    endfunction

    function automatic logic [7:0] msg_byte(input int sel, input int idx);
        return (sel == 1) ? 8'(8'h31 + idx) : 8'h00;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic clear();
        clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
    endtask

    task automatic feed_bit(input logic b, input int gap);
        bit_vld_i = 1'b1; bit_i = b; @(negedge clk); bit_vld_i = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    task automatic feed_msg(input int sel, input int gap, input int flip);
        for (int i = 0; i < msg_len(sel); i++)
            for (int k = 0; k < 8; k++)
                feed_bit(msg_byte(sel, i)[k] ^ (flip == i * 8 + k), gap);
    endtask

    task automatic feed_word(input logic [31:0] v, input int w, input int flip);
        for (int k = 0; k < w; k++) feed_bit(v[k] ^ (flip == k), 0);
    endtask

    task automatic read_fcs(input int w, output logic [31:0] v);
        v = '0;
        for (int k = 0; k < w; k++) begin
            v[k] = fcs_bit_o;
            send_i = 1'b1; @(negedge clk); send_i = 1'b0;
        end
    endtask

    initial begin
        #400000;
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int w;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(fcs_bit_o == 1'b0, "R1 fcs_bit after reset", 32'(fcs_bit_o), 0);
        check(match_o == 1'b0, "R1 match after reset", 32'(match_o), 0);
        wide_i = 1'b1;
        read_fcs(32, v);
        check(v == 32'h0, "R1 read after reset", v, 0);

        // Vector loop: generate (R3 R4 R5), then check mode (R7)
        for (int n = 0; n < NV; n++) begin
            wide_i = V_WIDE[n]; w = V_WIDE[n] ? 32 : 16;
            clear();
            feed_msg(V_SEL[n], 0, -1);
            read_fcs(w, v);
            check(v == V_EXP[n], V_WIDE[n] ? "R4 R5 wide fcs" : "R3 R5 narrow fcs", v, V_EXP[n]);
            check(fcs_bit_o == 1'b0, "R9 drained output", 32'(fcs_bit_o), 0);
            clear();
            feed_msg(V_SEL[n], 0, -1);
            feed_word(V_EXP[n], w, -1);
            check(match_o == 1'b1, "R7 good frame match", 32'(match_o), 1);
        end

        // R8: flipped FCS bit, wide
        wide_i = 1'b1; clear();
        feed_msg(1, 0, -1); feed_word(32'hCBF43926, 32, 0);
        check(match_o == 1'b0, "R8 flipped fcs bit", 32'(match_o), 0);
        // R8: flipped payload bit, narrow
        wide_i = 1'b0; clear();
        feed_msg(1, 0, 13); feed_word(32'h906E, 16, -1);
        check(match_o == 1'b0, "R8 flipped payload bit", 32'(match_o), 0);

        // R6: idle gaps between bits do not change the FCS
        wide_i = 1'b0; clear();
        feed_msg(1, 2, -1);
        repeat (3) @(negedge clk);
        read_fcs(16, v);
        check(v == 32'h906E, "R6 gaps", v, 32'h906E);

        // R2: clear in mid-frame restarts the computation
        wide_i = 1'b1; clear();
        feed_msg(2, 0, -1); feed_bit(1'b1, 0);
        clear();
        feed_msg(1, 0, -1);
        read_fcs(32, v);
        check(v == 32'hCBF43926, "R2 mid-frame clear", v, 32'hCBF43926);

        // R10: clear wins over absorb in the same cycle
        wide_i = 1'b1; clear();
        feed_msg(1, 0, -1);
        clr_i = 1'b1; bit_vld_i = 1'b1; bit_i = 1'b1; @(negedge clk);
        clr_i = 1'b0; bit_vld_i = 1'b0;
        read_fcs(32, v);
        check(v == 32'h0, "R10 clear over absorb", v, 0);
        // R10: absorb wins over send
        clear();
        send_i = 1'b1;
        feed_msg(1, 0, -1);
        send_i = 1'b0;
        read_fcs(32, v);
        check(v == 32'hCBF43926, "R10 absorb over send", v, 32'hCBF43926);

        // R11: a narrow frame leaves the wide view's upper half preset
        wide_i = 1'b0; clear();
        feed_msg(1, 0, -1);
        wide_i = 1'b1;
        send_i = 1'b1; repeat (16) @(negedge clk); send_i = 1'b0;
        read_fcs(16, v);
        check(v == 32'h0, "R11 upper half untouched", v, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule